// File: doc/BRIEF.md
# Cascadable Synchronous Loadable Counter

This block is a binary up-counter, 4 bits wide by default. Its state changes only on the rising clock edge. On an edge it can take a new value from a parallel data input, step up by one, or keep its value. Two active-high enables control stepping. The parallel enable only allows or blocks the step. The chain enable also gates the terminal-count output, and that output is what links stages together.

To build a wider counter, join several instances. The terminal count of each stage drives the chain enable of the next stage. All stages share the clock, the load input and the parallel enable. The chain then behaves as one wide binary counter, with no gating between stages.

A build-time parameter selects the reset style. One choice is an active-low reset that clears the state at once, with no clock. The other is an active-low clear that acts on the next rising edge and outranks every other control.

Top module: `cascadable_counter`

## Requirements
- R1: When reset is inactive and `load_n` is 0 at a rising edge, `count` takes `data_in` on that edge, whatever `en_par` and `en_chain` are.
- R2: When `load_n` is 1 and both `en_par` and `en_chain` are 1 at a rising edge, `count` increases by one on that edge.
- R3: When `load_n` is 1 and either `en_par` or `en_chain` is 0 at a rising edge, `count` keeps its value on that edge.
- R4: Counting is modulo 2^WIDTH. An increment from the all-ones value (15 for WIDTH=4) gives 0.
- R5: `term_cnt` is 1 exactly when `en_chain` is 1 and `count` is all ones. It follows a change of `en_chain` within the same cycle, with no clock edge.
- R6: With ASYNC_CLEAR=1, `rst_n`=0 forces `count` to 0 at once, with no clock edge. `count` stays 0 while `rst_n` is low, even when a load is requested.
- R7: With ASYNC_CLEAR=0, `rst_n`=0 at a rising edge sets `count` to 0 on that edge, over any load or count request.
- R8: Two stages, where the upper stage's `en_chain` is driven by the lower stage's `term_cnt`, count as one 8-bit counter. The chain wraps from 255 to 0. When the shared `en_par` is 0, the chain holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst_n | input | 1 | Active-low reset; immediate or edge-sampled, set by ASYNC_CLEAR |
| load_n | input | 1 | Active-low parallel load request |
| en_par | input | 1 | Active-high count enable; gates stepping only |
| en_chain | input | 1 | Active-high count enable; gates stepping and the terminal count |
| data_in | input | WIDTH | Value loaded when `load_n` is low |
| count | output | WIDTH | Registered counter state |
| term_cnt | output | 1 | High when `count` is all ones and `en_chain` is high |

## Verification
The bench targets the priority order. It loads every start value and then applies every combination of load, both enables and the edge-sampled clear. A design that let an enable block a load, or let a load win over the synchronous clear, would leave the wrong value in `count`. It also checks the step from all ones to zero, which catches a counter that saturates or carries into a missing bit.

It also checks that `term_cnt` follows `en_chain` within the same cycle. A terminal count registered on the clock would lag by one cycle and break the cascade. It also checks that an immediate reset clears the counter between clock edges. A design that sampled that reset on the clock would still show the loaded value at that point.

Finally, a two-stage chain is run through all 256 states and back to zero. A stage whose carry was gated by the wrong enable would skip or repeat values at the 15-to-16 boundaries.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    // Action taken by the counter on the coming rising edge, listed in priority order.
    typedef enum logic [1:0] {
        ACT_CLEAR = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_STEP  = 2'd2,
        ACT_KEEP  = 2'd3
    } cnt_act_e;

endpackage

// File: rtl/cnt_mode_sel.sv
module cnt_mode_sel
    import cnt_pkg::*;
(
    input  logic     sync_clr,
    input  logic     load_n,
    input  logic     en_par,
    input  logic     en_chain,
    output cnt_act_e act
);

    // Fixed priority: clear, then load, then step, then keep.
    always_comb begin
        if (sync_clr) begin
            act = ACT_CLEAR;
        end else if (!load_n) begin
            act = ACT_LOAD;
        end else if (en_par && en_chain) begin
            act = ACT_STEP;
        end else begin
            act = ACT_KEEP;
        end
    end

endmodule

// File: rtl/cnt_next.sv
module cnt_next
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  cnt_act_e         act,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] inc_value;

    // The adder drops the carry out, so the count wraps modulo 2^WIDTH.
    assign inc_value = cur + ONE;

    always_comb begin
        unique case (act)
            ACT_CLEAR: nxt = '0;
            ACT_LOAD:  nxt = data_in;
            ACT_STEP:  nxt = inc_value;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/cnt_term_dec.sv
module cnt_term_dec #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             en_chain,
    output logic             term_cnt
);

    logic all_ones;

    assign all_ones = &cur;

    // Combinational, so the next stage sees en_chain changes within the same cycle.
    assign term_cnt = en_chain & all_ones;

endmodule

// File: rtl/cascadable_counter.sv
module cascadable_counter
    import cnt_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter bit ASYNC_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             en_par,
    input  logic             en_chain,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] count,
    output logic             term_cnt
);

    localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE     = {{(WIDTH-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [WIDTH-1:0] value;
    } cnt_state_t;

    cnt_state_t       st_d;
    cnt_state_t       st_q;
    cnt_act_e         act;
    logic             sync_clr;
    logic [WIDTH-1:0] nxt_value;

    // In immediate-reset builds the edge-sampled clear is never used.
    assign sync_clr = ASYNC_CLEAR ? 1'b0 : !rst_n;

    cnt_mode_sel u_sel (
        .sync_clr (sync_clr),
        .load_n   (load_n),
        .en_par   (en_par),
        .en_chain (en_chain),
        .act      (act)
    );

    cnt_next #(.WIDTH(WIDTH)) u_next (
        .act     (act),
        .cur     (st_q.value),
        .data_in (data_in),
        .nxt     (nxt_value)
    );

    cnt_term_dec #(.WIDTH(WIDTH)) u_term (
        .cur      (st_q.value),
        .en_chain (en_chain),
        .term_cnt (term_cnt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.value = nxt_value;
    end

    generate
        if (ASYNC_CLEAR) begin : g_async_clr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            // R6: while reset is held low, the state reads zero at every edge.
            always @(posedge clk) begin
                if (!rst_n) begin
                    assert_async_clear_R6: assert (count == '0)
                        else $error("R6 count not cleared by immediate reset");
                end
            end
        end else begin : g_sync_clr
            always_ff @(posedge clk) begin
                st_q <= st_d;
            end

            // R7: the first edge with reset released sees a cleared state.
            assert_sync_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> count == '0);
        end
    endgenerate

    assign count = st_q.value;

    assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> count == $past(data_in));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_par && en_chain) |=> count == WIDTH'($past(count) + ONE));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(en_par && en_chain)) |=> $stable(count));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_par && en_chain && count == TOP_VAL) |=> count == '0);

    assert_term_R5: assert property (@(posedge clk) disable iff (!rst_n)
        term_cnt == (en_chain && count == TOP_VAL));

endmodule

// File: tb/test_cascadable_counter.sv
`timescale 1ns/1ps
module test_cascadable_counter;

    logic       clk = 1'b0;
    logic       rst_a;
    logic       rst_s;
    logic       rst_c;
    logic       load_n;
    logic       en_par;
    logic       en_chain;
    logic [3:0] din;
    logic [3:0] cnt_a;
    logic [3:0] cnt_s;
    logic       term_a;
    logic       term_s;

    logic       c_en_par;
    logic [3:0] c_lo;
    logic [3:0] c_hi;
    logic       c_term_lo;
    logic       c_term_hi;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_a   = 0;
    int exp_s   = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    cascadable_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) i_cascadable_counter (
        .clk(clk), .rst_n(rst_a), .load_n(load_n), .en_par(en_par), .en_chain(en_chain),
        .data_in(din), .count(cnt_a), .term_cnt(term_a));

    cascadable_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) i_sync (
        .clk(clk), .rst_n(rst_s), .load_n(load_n), .en_par(en_par), .en_chain(en_chain),
        .data_in(din), .count(cnt_s), .term_cnt(term_s));

    cascadable_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) i_stage_lo (
        .clk(clk), .rst_n(rst_c), .load_n(1'b1), .en_par(c_en_par), .en_chain(1'b1),
        .data_in(4'd0), .count(c_lo), .term_cnt(c_term_lo));

    cascadable_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) i_stage_hi (
        .clk(clk), .rst_n(rst_c), .load_n(1'b1), .en_par(c_en_par), .en_chain(c_term_lo),
        .data_in(4'd0), .count(c_hi), .term_cnt(c_term_hi));

    task automatic chk(input string tag, input int actual, input int expected);
        n_tests++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, actual, expected);
        end
    endtask

    function automatic int model(input int cur, input bit ld, input bit ep, input bit et, input int d);
        if (!ld) return d;
        if (ep && et) return (cur + 1) % 16;
        return cur;
    endfunction

    // One cycle on the two single-stage instances, called just after a falling edge.
    task automatic cycle_ab(input bit ld, input bit ep, input bit et, input int d, input bit rs);
        string tag;
        load_n = ld; en_par = ep; en_chain = et; din = 4'(d); rst_s = rs;
        #1;
        chk("R5 term_a", int'(term_a), int'(et && exp_a == 15));
        if (rs) chk("R5 term_s", int'(term_s), int'(et && exp_s == 15));
        if (!ld)           tag = "R1";
        else if (ep && et) tag = (exp_a == 15) ? "R4" : "R2";
        else               tag = "R3";
        exp_a = model(exp_a, ld, ep, et, d);
        exp_s = rs ? model(exp_s, ld, ep, et, d) : 0;
        @(negedge clk);
        chk({tag, " async-reset instance"}, int'(cnt_a), exp_a);
        chk(rs ? {tag, " sync-reset instance"} : "R7 sync clear", int'(cnt_s), exp_s);
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int cval;
        rst_a = 1'b1; rst_s = 1'b1; rst_c = 1'b1;
        load_n = 1'b1; en_par = 1'b0; en_chain = 1'b0; din = 4'd0; c_en_par = 1'b0;
        #3;
        rst_a = 1'b0; rst_s = 1'b0; rst_c = 1'b0;
        @(negedge clk);
        chk("R6 reset state", int'(cnt_a), 0);
        chk("R7 reset state", int'(cnt_s), 0);
        chk("R5 term at reset", int'(term_a), 0);
        rst_a = 1'b1; rst_s = 1'b1; rst_c = 1'b1;
        exp_a = 0; exp_s = 0;

        // Every start value against every control combination (R1 R2 R3 R4 R7).
        for (int d = 0; d < 16; d++) begin
            for (int c = 0; c < 16; c++) begin
                cycle_ab(1'b0, c[2], c[1], d, 1'b1);
                cycle_ab(c[3], c[2], c[1], (~d) & 15, c[0]);
            end
        end

        // R4: explicit wrap through the top value.
        cycle_ab(1'b0, 1'b0, 1'b0, 14, 1'b1);
        cycle_ab(1'b1, 1'b1, 1'b1, 0, 1'b1);
        cycle_ab(1'b1, 1'b1, 1'b1, 0, 1'b1);
        cycle_ab(1'b1, 1'b1, 1'b1, 0, 1'b1);
        chk("R4 wrap landed on 1", int'(cnt_a), 1);

        // R5: term follows en_chain with no clock edge.
        cycle_ab(1'b0, 1'b0, 1'b0, 15, 1'b1);
        en_chain = 1'b1; #2;
        chk("R5 term rises with en_chain", int'(term_a), 1);
        en_chain = 1'b0; #2;
        chk("R5 term falls with en_chain", int'(term_a), 0);

        // R6: immediate clear between edges, held across an edge with a load request.
        cycle_ab(1'b0, 1'b0, 1'b0, 9, 1'b1);
        #5;
        rst_a = 1'b0;
        #2;
        chk("R6 clear without edge", int'(cnt_a), 0);
        load_n = 1'b0; din = 4'd6;
        @(negedge clk);
        chk("R6 held low over load edge", int'(cnt_a), 0);
        rst_a = 1'b1; load_n = 1'b1; exp_a = 0;

        // R8: two-stage chain through all 256 states and back to zero.
        rst_c = 1'b0; #2; rst_c = 1'b1;
        c_en_par = 1'b1;
        cval = 0;
        for (int i = 0; i < 256; i++) begin
            #1;
            chk("R8 upper term at 255", int'(c_term_hi), int'(cval == 255));
            @(negedge clk);
            cval = (cval + 1) % 256;
            chk("R8 chained value", int'({c_hi, c_lo}), cval);
        end
        chk("R8 wrap to zero", int'({c_hi, c_lo}), 0);
        repeat (20) @(negedge clk);
        cval = 20;
        c_en_par = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 chain holds", int'({c_hi, c_lo}), cval);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule